// File: doc/BRIEF.md
# Register-pair stack and memory transfer sequencer

This block moves 16-bit register pairs of an 8-bit processor between its register file and a byte-wide memory port. Memory access is one byte per cycle. It pushes a pair onto a stack that grows downward and pops a pair back from it. It swaps HL with the two bytes at the top of the stack, and it loads or stores HL at a direct 16-bit address. Two further operations need no memory access: the HL/DE swap and copying HL into the stack pointer.

The block owns eight byte registers and the 16-bit stack pointer. The accumulator and the flag byte travel together as one pair. A caller pulses `start` with an operation code, a pair selector and an address. The block then drives the memory port for the needed number of cycles. It signals completion with a one-cycle `done`, and its register file and stack pointer are visible at all times. A byte write port loads registers while the block is idle.

Top module: `pair_xfer_seq`

## Requirements
- R1: Push (op 0) takes two cycles. In the first cycle it writes the high register of the pair to SP-1. In the second it writes the low register to SP-2. SP ends at SP-2. Pair select values are: 0 = B:C, 1 = D:E, 2 = H:L, 3 = A:F (A high, flags low).
- R2: Pop (op 1) takes two cycles and writes nothing to memory. In the first cycle it reads the byte at SP into the low register. In the second it reads the byte at SP+1 into the high register. SP ends at SP+2.
- R3: Stack-top swap (op 2) takes four cycles. It reads SP, then reads SP+1, then writes the old L to SP, then writes the old H to SP+1. Afterwards L holds the old byte at SP and H holds the old byte at SP+1. SP is unchanged throughout.
- R4: Direct HL load (op 3) reads `addr_in` into L and then `addr_in`+1 into H, one cycle each.
- R5: Direct HL store (op 4) writes L to `addr_in` and then H to `addr_in`+1, one cycle each.
- R6: HL/DE swap (op 5) exchanges H with D and L with E. It makes no memory access, and `done` rises in the cycle after `start`.
- R7: Copy HL to SP (op 6) loads SP with {H,L} and makes no memory access. Op 7 does nothing except raise `done`.
- R8: `done` is high for exactly one cycle. It comes in the cycle after the last memory access, or in the cycle after `start` for ops 5 to 7. `mem_we` is high only while `busy` is high.
- R9: All address arithmetic on SP and on `addr_in` wraps modulo 2^16.
- R10: `start` is ignored while `busy` is high. `wr_en` is ignored while busy and in any cycle where `start` is also high.
- R11: After reset all registers and SP are zero, `busy`, `done` and `mem_we` are low, and the register view follows the layout "byte i of `rf_view` is register i". The index order is B=0, C=1, D=2, E=3, H=4, L=5, F=6, A=7, and `wr_sel` uses the same indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (idle only) |
| op | input | 3 | Operation code |
| pair | input | 2 | Register pair select |
| addr_in | input | 16 | Direct address for HL load/store |
| wr_en | input | 1 | Register write enable (idle only) |
| wr_sel | input | 3 | Register index to write |
| wr_data | input | 8 | Register write value |
| mem_rdata | input | 8 | Memory read byte for the current address |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_view | output | 64 | All eight registers, byte i = register i |
| sp_view | output | 16 | Stack pointer |

## Verification
The hardest case to reach from the ports is a stack-top swap or a push whose addresses straddle the 0xFFFF/0x0000 boundary. To reach it, the stack pointer is first steered to the edge through a copy from HL. A second hard case is an intruding `start` or register write arriving mid-sequence. The bench raises both inputs during the first access cycle of a running push and then confirms that the registers and the access trace are untouched. Random operation streams on top of this mix pairs, addresses and register contents. Every access and every final state is compared against a bench model.

// File: rtl/pair_xfer_seq.sv
module pair_xfer_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [1:0]    pair,
  input  logic [AW-1:0] addr_in,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          busy,
  output logic          done,
  output logic [8*DW-1:0] rf_view,
  output logic [AW-1:0] sp_view
);
  localparam logic [2:0] OP_PUSH = 3'd0, OP_POP = 3'd1, OP_XTOP = 3'd2,
                         OP_LDHL = 3'd3, OP_STHL = 3'd4, OP_XDE = 3'd5,
                         OP_SPHL = 3'd6;
  localparam int RB = 0, RD = 2, RE = 3, RH = 4, RL = 5, RF = 6, RA = 7;

  logic [DW-1:0] rf [8];
  logic [AW-1:0] sp;
  logic [AW-1:0] areg;
  logic [2*DW-1:0] tmp;
  logic [2:0] op_q;
  logic [1:0] pr_q;
  logic [1:0] step;
  logic last;
  logic [2:0] hi_idx, lo_idx;

  assign hi_idx = (pr_q == 2'd3) ? 3'(RA) : {pr_q, 1'b0};
  assign lo_idx = (pr_q == 2'd3) ? 3'(RF) : {pr_q, 1'b1};
  assign last   = (op_q == OP_XTOP) ? (step == 2'd3) : (step == 2'd1);
  assign sp_view = sp;

  for (genvar i = 0; i < 8; i++) begin : g_view
    assign rf_view[DW*i +: DW] = rf[i];
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    if (busy) begin
      case (op_q)
        OP_PUSH: begin
          mem_addr  = sp - 1'b1;
          mem_wdata = (step == 2'd0) ? rf[hi_idx] : rf[lo_idx];
          mem_we    = 1'b1;
        end
        OP_POP: mem_addr = sp;
        OP_XTOP: begin
          mem_addr  = step[0] ? sp + 1'b1 : sp;
          mem_we    = step[1];
          mem_wdata = step[0] ? rf[RH] : rf[RL];
        end
        OP_LDHL: mem_addr = step[0] ? areg + 1'b1 : areg;
        OP_STHL: begin
          mem_addr  = step[0] ? areg + 1'b1 : areg;
          mem_wdata = step[0] ? rf[RH] : rf[RL];
          mem_we    = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= '0;
      sp   <= '0;
      areg <= '0;
      tmp  <= '0;
      op_q <= '0;
      pr_q <= '0;
      step <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          case (op)
            OP_PUSH, OP_POP, OP_XTOP, OP_LDHL, OP_STHL: begin
              busy <= 1'b1;
              step <= '0;
              op_q <= op;
              pr_q <= pair;
              areg <= addr_in;
            end
            OP_XDE: begin
              rf[RH] <= rf[RD];
              rf[RD] <= rf[RH];
              rf[RL] <= rf[RE];
              rf[RE] <= rf[RL];
              done   <= 1'b1;
            end
            OP_SPHL: begin
              sp   <= {rf[RH], rf[RL]};
              done <= 1'b1;
            end
            default: done <= 1'b1;
          endcase
        end else if (wr_en) begin
          rf[wr_sel] <= wr_data;
        end
      end else begin
        step <= step + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        case (op_q)
          OP_PUSH: sp <= sp - 1'b1;
          OP_POP: begin
            sp <= sp + 1'b1;
            if (step == 2'd0) rf[lo_idx] <= mem_rdata;
            else              rf[hi_idx] <= mem_rdata;
          end
          OP_XTOP: begin
            if (step == 2'd0) tmp[DW-1:0]    <= mem_rdata;
            if (step == 2'd1) tmp[2*DW-1:DW] <= mem_rdata;
            if (step == 2'd3) begin
              rf[RL] <= tmp[DW-1:0];
              rf[RH] <= tmp[2*DW-1:DW];
            end
          end
          OP_LDHL: begin
            if (step == 2'd0) rf[RL] <= mem_rdata;
            else              rf[RH] <= mem_rdata;
          end
          default: ;
        endcase
      end
    end
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_we_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  a_r1_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_PUSH) |=> sp == $past(sp) - 1'b1);
  a_r2_pop_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_POP) |-> !mem_we);
  a_r3_sp_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_XTOP) |=> $stable(sp));
  a_r6_swap_nomem: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == OP_XDE) |=> (done && !mem_we && !busy));
  a_r10_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && $stable(op_q)));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && mem_addr == '0));
endmodule

// File: tb/tb_pair_xfer_seq.sv
module tb_pair_xfer_seq;
  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [2:0] op = 0;
  logic [1:0] pair = 0;
  logic [15:0] addr_in = 0;
  logic wr_en = 0;
  logic [2:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic mem_we, busy, done;
  logic [63:0] rf_view;
  logic [15:0] sp_view;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] mem [256];
  logic [7:0] m_rf [8];
  logic [15:0] m_sp;

  always #10 clk = ~clk;

  pair_xfer_seq dut (.*);

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] packm();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = m_rf[i];
    return v;
  endfunction

  task automatic set_reg(input int idx, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1; wr_sel = 3'(idx); wr_data = v;
    @(negedge clk);
    wr_en = 0;
    m_rf[idx] = v;
  endtask

  task automatic do_op(input string req, input logic [2:0] o, input logic [1:0] p,
                       input logic [15:0] a, input bit intrude);
    logic [15:0] ea [4];
    logic ew [4];
    logic [7:0] ed [4];
    int n;
    int hi, lo;
    logic [7:0] r [8];
    logic [15:0] ns;
    logic [7:0] t;
    hi = (p == 3) ? 7 : 2 * p;
    lo = (p == 3) ? 6 : 2 * p + 1;
    for (int i = 0; i < 8; i++) r[i] = m_rf[i];
    ns = m_sp;
    n = 0;
    for (int i = 0; i < 4; i++) begin ea[i] = 0; ew[i] = 0; ed[i] = 0; end
    case (o)
      3'd0: begin
        n = 2;
        ea[0] = m_sp - 16'd1; ew[0] = 1; ed[0] = m_rf[hi];
        ea[1] = m_sp - 16'd2; ew[1] = 1; ed[1] = m_rf[lo];
        ns = m_sp - 16'd2;
      end
      3'd1: begin
        n = 2;
        ea[0] = m_sp; ea[1] = m_sp + 16'd1;
        r[lo] = mem[ea[0][7:0]]; r[hi] = mem[ea[1][7:0]];
        ns = m_sp + 16'd2;
      end
      3'd2: begin
        n = 4;
        ea[0] = m_sp; ea[1] = m_sp + 16'd1;
        ea[2] = m_sp; ew[2] = 1; ed[2] = m_rf[5];
        ea[3] = m_sp + 16'd1; ew[3] = 1; ed[3] = m_rf[4];
        r[5] = mem[ea[0][7:0]]; r[4] = mem[ea[1][7:0]];
      end
      3'd3: begin
        n = 2;
        ea[0] = a; ea[1] = a + 16'd1;
        r[5] = mem[ea[0][7:0]]; r[4] = mem[ea[1][7:0]];
      end
      3'd4: begin
        n = 2;
        ea[0] = a; ew[0] = 1; ed[0] = m_rf[5];
        ea[1] = a + 16'd1; ew[1] = 1; ed[1] = m_rf[4];
      end
      3'd5: begin
        t = r[4]; r[4] = r[2]; r[2] = t;
        t = r[5]; r[5] = r[3]; r[3] = t;
      end
      3'd6: ns = {m_rf[4], m_rf[5]};
      default: ;
    endcase
    @(negedge clk);
    op = o; pair = p; addr_in = a; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < n; i++) begin
      chk({req, " addr"}, 64'(mem_addr), 64'(ea[i]));
      chk({req, " we"}, 64'(mem_we), 64'(ew[i]));
      if (ew[i]) chk({req, " wdata"}, 64'(mem_wdata), 64'(ed[i]));
      chk("R8 busy during access", 64'({busy, done}), 64'(2'b10));
      if (intrude && i == 0) begin
        start = 1; op = 3'd5; wr_en = 1; wr_sel = 3'd0; wr_data = 8'hEE;
      end
      @(negedge clk);
      if (intrude && i == 0) begin start = 0; wr_en = 0; end
    end
    chk("R8 done pulse", 64'({done, busy, mem_we}), 64'(3'b100));
    for (int i = 0; i < 8; i++) m_rf[i] = r[i];
    m_sp = ns;
    chk({req, " regs"}, rf_view, packm());
    chk({req, " sp"}, 64'(sp_view), 64'(m_sp));
    @(negedge clk);
    chk("R8 done one cycle", 64'(done), 64'(0));
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 8; i++) m_rf[i] = 0;
    m_sp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset regs", rf_view, 64'd0);
    chk("R11 reset sp", 64'(sp_view), 64'd0);
    chk("R11 reset ctl", 64'({busy, done, mem_we}), 64'd0);

    for (int i = 0; i < 8; i++) set_reg(i, 8'(8'h11 * (i + 1)));
    chk("R11 view layout", rf_view, packm());
    do_op("R1 R9 push BC at sp 0", 3'd0, 2'd0, 16'h0, 0);
    do_op("R2 R9 pop DE", 3'd1, 2'd1, 16'h0, 0);
    do_op("R1 push AF", 3'd0, 2'd3, 16'h0, 0);
    do_op("R2 pop AF", 3'd1, 2'd3, 16'h0, 0);
    set_reg(4, 8'hFF); set_reg(5, 8'hFF);
    do_op("R7 copy HL to sp", 3'd6, 2'd0, 16'h0, 0);
    do_op("R3 R9 stack top swap at FFFF", 3'd2, 2'd0, 16'h0, 0);
    do_op("R4 R9 load HL at FFFF", 3'd3, 2'd0, 16'hFFFF, 0);
    do_op("R5 store HL", 3'd4, 2'd0, 16'h1234, 0);
    do_op("R6 HL DE swap", 3'd5, 2'd0, 16'h0, 0);
    do_op("R7 op7 no effect", 3'd7, 2'd0, 16'h0, 0);
    do_op("R10 intrusion during push", 3'd0, 2'd2, 16'h0, 1);
    do_op("R10 intrusion during swap", 3'd2, 2'd0, 16'h0, 1);

    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 3) == 0)
        set_reg(int'($urandom_range(0, 7)), 8'($urandom));
      do_op("R1 R2 R3 R4 R5 R6 R7 random", 3'($urandom_range(0, 7)),
            2'($urandom_range(0, 3)), 16'($urandom), ($urandom_range(0, 9) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule